// File: doc/BRIEF.md
# Multiprocessor Global Control Registers

This block is the shared control register file of a small multiprocessor. It sits on a simple 64-bit register bus. Every access carries the index of the virtual processor (VP) that issued it. A global page holds the fixed identification registers, plus the base and enable settings for the interrupt-controller region and the power-controller region. The block drives those settings out as region base/enable pairs, so that the system decoder can place each region.

Each VP also owns two registers: a reset-base register and an "other" pointer. They are reached through two aliased windows. The local window always addresses the requesting VP's own copy. The remote window addresses the VP that the requester's other pointer selects. A VP can therefore set up another VP's boot vector before it releases that VP. Each VP's exception-vector base is driven out continuously, derived from its reset base.

Top module: `mp_gcr_top`

Address map: the global page is at 0x0000, the local window at 0x2000 and the remote window at 0x4000. Address bits [15:12] select the page and bits [11:0] give the offset.

## Requirements
- R1: After reset, both region bases and both region enables are 0. Every VP's other pointer is 0 and every VP's reset base is 0xBFC00000, so every exception base is 0xFFFFFFFF_BFC00000.
- R2: These global offsets read as constants:
  - offset 0x000 (configuration) reads 0;
  - offset 0x008 reads the SELF_BASE parameter;
  - offset 0x030 reads the REVISION parameter (default 0x800);
  - offset 0x130 (L2 configuration) reads only bit 20, the bypass flag.
- R3: Offset 0x0D0 reads 1 when GIC_PRESENT is set and 0 otherwise. Offset 0x0F0 does the same for CPC_PRESENT.
- R4: The region registers are at 0x080 (interrupt controller) and 0x088 (power controller). A write to one of them stores only bits [47:15] and bit 0, and only when that peripheral is present. The stored value reads back at the same offset. Its address field (mask 0x0000FFFF_FFFF8000) drives the region base output and bit 0 drives the region enable output. The register of an absent peripheral stays 0.
- R5: The per-VP configuration register at window offset 0x010 reads NUM_VP-1 in both windows.
- R6: In the local window, offset 0x018 (other pointer) and offset 0x020 (reset base) reach the requesting VP's own registers.
- R7: In the remote window, the same two offsets reach, for both reads and writes, the registers of the VP named by the requester's other pointer.
- R8: A write to an other pointer keeps data bits [5:0]. It is accepted only when that value is less than NUM_VP; otherwise the pointer keeps its value.
- R9: A reset-base write keeps bits [31:12]. Each VP's exception base output equals its reset base sign-extended from bit 31, and it changes in the cycle after a write through either window.
- R10: A read of an undecoded offset returns 0. A write to one changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_vp | input | VIW | Index of the requesting VP |
| bus_addr | input | ADDR_W | Byte offset in the block |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| gic_base_o | output | 64 | Interrupt-controller region base |
| gic_en_o | output | 1 | Interrupt-controller region enable |
| cpc_base_o | output | 64 | Power-controller region base |
| cpc_en_o | output | 1 | Power-controller region enable |
| exc_base_o | output | 64*NUM_VP | Exception base for each VP; VP i is in slice [64*i +: 64] |

## Verification
Read data is registered, so it appears one clock edge after the cycle in which the read strobe is sampled. Writes change the stored registers, the region outputs and the exception bases at that same edge. The bench drives every strobe on a falling edge and holds it for one full cycle. It samples the read data and the outputs at the next falling edge, exactly one edge after the access. No check looks at a value in the cycle where it is still changing.

// File: rtl/mp_gcr_pkg.sv
package mp_gcr_pkg;
  // Kept bits of a region register: address [47:15] and enable bit 0.
  localparam logic [63:0] REGION_KEEP = 64'h0000_FFFF_FFFF_8001;
  localparam logic [63:0] REGION_ADDR = 64'h0000_FFFF_FFFF_8000;
  // Kept bits of a reset-base register.
  localparam logic [63:0] RBASE_KEEP  = 64'h0000_0000_FFFF_F000;
  localparam logic [63:0] RBASE_INIT  = 64'h0000_0000_BFC0_0000;
  localparam int          PTR_W       = 6;
  localparam int          L2_BYPASS   = 20;

  // Page select, taken from address bits [15:12].
  localparam logic [3:0]  PG_GLOBAL   = 4'h0;
  localparam logic [3:0]  PG_LOCAL    = 4'h2;
  localparam logic [3:0]  PG_REMOTE   = 4'h4;

  // Offsets in the global page.
  localparam logic [11:0] G_CONFIG    = 12'h000;
  localparam logic [11:0] G_SELF      = 12'h008;
  localparam logic [11:0] G_REV       = 12'h030;
  localparam logic [11:0] G_GIC       = 12'h080;
  localparam logic [11:0] G_CPC       = 12'h088;
  localparam logic [11:0] G_GIC_ST    = 12'h0D0;
  localparam logic [11:0] G_CPC_ST    = 12'h0F0;
  localparam logic [11:0] G_L2        = 12'h130;

  // Offsets inside each per-VP window.
  localparam logic [11:0] V_CONFIG    = 12'h010;
  localparam logic [11:0] V_OTHER     = 12'h018;
  localparam logic [11:0] V_RBASE     = 12'h020;

  function automatic logic [63:0] region_mask(input logic [63:0] v);
    return v & REGION_KEEP;
  endfunction

  function automatic logic [63:0] region_addr(input logic [63:0] v);
    return v & REGION_ADDR;
  endfunction

  function automatic logic [63:0] rbase_mask(input logic [63:0] v);
    return v & RBASE_KEEP;
  endfunction

  function automatic logic [63:0] exc_from_rbase(input logic [63:0] rb);
    return {{32{rb[31]}}, rb[31:0]};
  endfunction

  function automatic logic ptr_ok(input logic [63:0] v, input int nvp);
    return int'(v[PTR_W-1:0]) < nvp;
  endfunction
endpackage

// File: rtl/mp_region_reg.sv
module mp_region_reg
  import mp_gcr_pkg::*;
#(
  parameter bit PRESENT = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [63:0] wdata,
  output logic [63:0] val_q,
  output logic [63:0] base_o,
  output logic        en_o
);
  // A write lands only when the peripheral is present.
  logic load;
  assign load = wr && PRESENT;

  always_ff @(posedge clk) begin
    if (!rst_n)    val_q <= '0;
    else if (load) val_q <= region_mask(wdata);
  end

  assign base_o = region_addr(val_q);
  assign en_o   = val_q[0];

  AST_REGION_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (base_o == {16'h0, $past(wdata[47:15]), 15'h0}) && (en_o == $past(wdata[0]))); // R4

  generate
    if (!PRESENT) begin : g_absent
      AST_ABSENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (val_q == '0) && !en_o); // R4
    end
  endgenerate
endmodule

// File: rtl/mp_vp_ctx.sv
module mp_vp_ctx
  import mp_gcr_pkg::*;
#(
  parameter int NUM_VP = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_rbase,
  input  logic             wr_ptr,
  input  logic [63:0]      wdata,
  output logic [63:0]      rbase_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [63:0]      exc_o
);
  // Range check on the pointer, brought out for the assertions.
  logic ptr_accept;
  assign ptr_accept = wr_ptr && ptr_ok(wdata, NUM_VP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbase_q <= rbase_mask(RBASE_INIT);
      ptr_q   <= '0;
    end else begin
      if (wr_rbase)   rbase_q <= rbase_mask(wdata);
      if (ptr_accept) ptr_q   <= wdata[PTR_W-1:0];
    end
  end

  assign exc_o = exc_from_rbase(rbase_q);

  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUM_VP); // R8
  AST_PTR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ptr && !ptr_accept) |=> $stable(ptr_q)); // R8
  AST_EXC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rbase |=> exc_o == {{32{$past(wdata[31])}}, $past(wdata[31:12]), 12'h000}); // R9
endmodule

// File: rtl/mp_gcr_top.sv
module mp_gcr_top
  import mp_gcr_pkg::*;
#(
  parameter int          NUM_VP      = 1,
  parameter bit          GIC_PRESENT = 1'b1,
  parameter bit          CPC_PRESENT = 1'b1,
  parameter logic [63:0] REVISION    = 64'h800,
  parameter logic [63:0] SELF_BASE   = 64'h1FBF_8000,
  parameter int          ADDR_W      = 16,
  localparam int         VIW         = (NUM_VP > 1) ? $clog2(NUM_VP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [VIW-1:0]       bus_vp,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic [63:0]          gic_base_o,
  output logic                 gic_en_o,
  output logic [63:0]          cpc_base_o,
  output logic                 cpc_en_o,
  output logic [64*NUM_VP-1:0] exc_base_o
);
  localparam int PG_W = ADDR_W - 12;

  // Address decode.
  logic [PG_W-1:0] page;
  logic [11:0]     ofs;
  logic            in_glb, in_loc, in_rem, in_vp;
  assign page   = bus_addr[ADDR_W-1:12];
  assign ofs    = bus_addr[11:0];
  assign in_glb = page == PG_W'(PG_GLOBAL);
  assign in_loc = page == PG_W'(PG_LOCAL);
  assign in_rem = page == PG_W'(PG_REMOTE);
  assign in_vp  = in_loc || in_rem;

  // Per-VP state, collected for the window redirect.
  logic [63:0]      rbase_arr [NUM_VP];
  logic [PTR_W-1:0] ptr_arr   [NUM_VP];
  logic [VIW-1:0]   tgt_idx;
  assign tgt_idx = in_rem ? ptr_arr[bus_vp][VIW-1:0] : bus_vp;

  // Region registers.
  logic [63:0] gic_val, cpc_val;
  logic        wr_gic, wr_cpc;
  assign wr_gic = bus_wr && in_glb && (ofs == G_GIC);
  assign wr_cpc = bus_wr && in_glb && (ofs == G_CPC);

  mp_region_reg #(.PRESENT(GIC_PRESENT)) u_gic (
    .clk(clk), .rst_n(rst_n), .wr(wr_gic), .wdata(bus_wdata),
    .val_q(gic_val), .base_o(gic_base_o), .en_o(gic_en_o)
  );

  mp_region_reg #(.PRESENT(CPC_PRESENT)) u_cpc (
    .clk(clk), .rst_n(rst_n), .wr(wr_cpc), .wdata(bus_wdata),
    .val_q(cpc_val), .base_o(cpc_base_o), .en_o(cpc_en_o)
  );

  // One context per VP; the local or remote window picks the target.
  logic wr_rbase_any, wr_ptr_any;
  assign wr_rbase_any = bus_wr && in_vp && (ofs == V_RBASE);
  assign wr_ptr_any   = bus_wr && in_vp && (ofs == V_OTHER);

  generate
    for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
      logic hit;
      assign hit = tgt_idx == VIW'(i);
      mp_vp_ctx #(.NUM_VP(NUM_VP)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_rbase (wr_rbase_any && hit),
        .wr_ptr   (wr_ptr_any && hit),
        .wdata    (bus_wdata),
        .rbase_q  (rbase_arr[i]),
        .ptr_q    (ptr_arr[i]),
        .exc_o    (exc_base_o[64*i +: 64])
      );
    end
  endgenerate

  // Read mux.
  logic [63:0] rd_val;
  logic        rd_hit;
  always_comb begin
    rd_val = '0;
    rd_hit = 1'b1;
    if (in_glb) begin
      case (ofs)
        G_CONFIG: rd_val = '0;
        G_SELF:   rd_val = SELF_BASE;
        G_REV:    rd_val = REVISION;
        G_GIC:    rd_val = gic_val;
        G_CPC:    rd_val = cpc_val;
        G_GIC_ST: rd_val = 64'(GIC_PRESENT);
        G_CPC_ST: rd_val = 64'(CPC_PRESENT);
        G_L2:     rd_val = 64'h1 << L2_BYPASS;
        default:  rd_hit = 1'b0;
      endcase
    end else if (in_vp) begin
      case (ofs)
        V_CONFIG: rd_val = 64'(NUM_VP - 1);
        V_OTHER:  rd_val = 64'(ptr_arr[tgt_idx]);
        V_RBASE:  rd_val = rbase_arr[tgt_idx];
        default:  rd_hit = 1'b0;
      endcase
    end else begin
      rd_hit = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end

  AST_CONFIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_glb && ofs == G_CONFIG) |=> bus_rdata == '0); // R2
  AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_glb && ofs == G_GIC_ST) |=> bus_rdata[0] == GIC_PRESENT); // R3
  AST_VP_CONFIG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && in_vp && ofs == V_CONFIG) |=> int'(bus_rdata) == NUM_VP - 1); // R5
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> bus_rdata == '0); // R10
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_gic, wr_cpc, wr_rbase_any, wr_ptr_any})); // R10
endmodule

// File: tb/tb_mp_gcr_top.sv
`timescale 1ns/1ps
module tb_mp_gcr_top;
  localparam int NVP = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]        bus_vp = '0;
  logic [15:0]       bus_addr = '0;
  logic [63:0]       bus_wdata = '0;
  logic [63:0]       bus_rdata, gic_base_o, cpc_base_o;
  logic              gic_en_o, cpc_en_o;
  logic [64*NVP-1:0] exc_base_o;

  always #10 clk = ~clk;

  mp_gcr_top #(.NUM_VP(NVP), .GIC_PRESENT(1'b1), .CPC_PRESENT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_vp(bus_vp), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gic_base_o(gic_base_o), .gic_en_o(gic_en_o),
    .cpc_base_o(cpc_base_o), .cpc_en_o(cpc_en_o), .exc_base_o(exc_base_o)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%016h expected 0x%016h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] vp, input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_vp = vp; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] vp, input logic [15:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_vp = vp; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  vp;
    logic [15:0] addr;
    logic [63:0] data;   // write data, or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 2'd0, 16'h0000, 64'h0, 4'd2},                    // R2 configuration
    '{1'b0, 2'd0, 16'h0008, 64'h1FBF_8000, 4'd2},            // R2 self base
    '{1'b0, 2'd0, 16'h0030, 64'h800, 4'd2},                  // R2 revision
    '{1'b0, 2'd0, 16'h0130, 64'h10_0000, 4'd2},              // R2 L2 bypass
    '{1'b0, 2'd0, 16'h00D0, 64'h1, 4'd3},                    // R3 gic present
    '{1'b0, 2'd0, 16'h00F0, 64'h0, 4'd3},                    // R3 cpc absent
    '{1'b0, 2'd2, 16'h2010, 64'h3, 4'd5},                    // R5 local window
    '{1'b0, 2'd1, 16'h4010, 64'h3, 4'd5},                    // R5 remote window
    '{1'b1, 2'd0, 16'h0080, 64'hFFFF_FFFF_FFFF_FFFF, 4'd4},  // R4
    '{1'b0, 2'd0, 16'h0080, 64'h0000_FFFF_FFFF_8001, 4'd4},  // R4 masked
    '{1'b1, 2'd0, 16'h0088, 64'hFFFF_FFFF_FFFF_FFFF, 4'd4},  // R4 absent
    '{1'b0, 2'd0, 16'h0088, 64'h0, 4'd4},                    // R4 absent stays 0
    '{1'b1, 2'd1, 16'h2018, 64'h43, 4'd8},                   // R8 masked to 3
    '{1'b0, 2'd1, 16'h2018, 64'h3, 4'd8},                    // R8
    '{1'b1, 2'd1, 16'h2018, 64'h5, 4'd8},                    // R8 out of range
    '{1'b0, 2'd1, 16'h2018, 64'h3, 4'd8},                    // R8 kept
    '{1'b1, 2'd1, 16'h4020, 64'h1234_5678_9ABC_DEFF, 4'd7},  // R7 write VP3
    '{1'b0, 2'd3, 16'h2020, 64'h9ABC_D000, 4'd7},            // R7 seen by VP3
    '{1'b0, 2'd0, 16'h2020, 64'hBFC0_0000, 4'd6},            // R6 VP0 untouched
    '{1'b1, 2'd1, 16'h4018, 64'h2, 4'd7},                    // R7 VP3 ptr=2
    '{1'b0, 2'd3, 16'h2018, 64'h2, 4'd7},                    // R7
    '{1'b0, 2'd1, 16'h4018, 64'h2, 4'd7},                    // R7 remote read
    '{1'b1, 2'd2, 16'h2020, 64'h7000_0123, 4'd6},            // R6 local write
    '{1'b0, 2'd3, 16'h4020, 64'h7000_0000, 4'd7},            // R7 VP3 -> VP2
    '{1'b1, 2'd0, 16'h0100, 64'hFFFF_FFFF_FFFF_FFFF, 4'd10}, // R10 undecoded
    '{1'b0, 2'd0, 16'h0100, 64'h0, 4'd10},                   // R10
    '{1'b0, 2'd0, 16'h2028, 64'h0, 4'd10},                   // R10
    '{1'b0, 2'd0, 16'h0080, 64'h0000_FFFF_FFFF_8001, 4'd10}, // R10 no side effect
    '{1'b0, 2'd3, 16'h4010, 64'h3, 4'd5}                     // R5
  };

  task automatic check_reset_state();
    logic [63:0] d;
    check("R1 gic base", gic_base_o, 64'h0);
    check("R1 gic en", 64'(gic_en_o), 64'h0);
    check("R1 cpc en", 64'(cpc_en_o), 64'h0);
    for (int k = 0; k < NVP; k++)
      check("R1 exc base", exc_base_o[64*k +: 64], 64'hFFFF_FFFF_BFC0_0000);
    bus_read(2'd1, 16'h2018, d); check("R1 ptr", d, 64'h0);
    bus_read(2'd3, 16'h2020, d); check("R1 rbase", d, 64'hBFC0_0000);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_reset_state();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].vp, VEC[i].addr, VEC[i].data);
      else begin
        bus_read(VEC[i].vp, VEC[i].addr, d);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].data);
      end
    end

    // R4 region outputs
    check("R4 gic base out", gic_base_o, 64'h0000_FFFF_FFFF_8000);
    check("R4 gic en out", 64'(gic_en_o), 64'h1);
    check("R4 cpc base out", cpc_base_o, 64'h0);
    check("R4 cpc en out", 64'(cpc_en_o), 64'h0);
    bus_write(2'd0, 16'h0080, 64'h1234_0000);
    check("R4 gic base new", gic_base_o, 64'h1234_0000);
    check("R4 gic disabled", 64'(gic_en_o), 64'h0);

    // R9 exception bases
    check("R9 exc vp3", exc_base_o[64*3 +: 64], 64'hFFFF_FFFF_9ABC_D000);
    check("R9 exc vp2", exc_base_o[64*2 +: 64], 64'h0000_0000_7000_0000);
    check("R9 exc vp0", exc_base_o[64*0 +: 64], 64'hFFFF_FFFF_BFC0_0000);
    bus_write(2'd0, 16'h2020, 64'hFFFF_0000_8000_0FFF);
    check("R9 exc vp0 next cycle", exc_base_o[64*0 +: 64], 64'hFFFF_FFFF_8000_0000);

    // R1 reset in mid run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check_reset_state();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule